// File: doc/BRIEF.md
# Output Rail Ramp Sequencer

This block sequences a single output rail through turn-on, steady operation and turn-off, and drives the digital voltage setpoint that an analog loop regulates to. The rail is enabled when the run input is high and the operating command is not "off". Once enabled, the block waits out a turn-on delay, then moves the setpoint to its target in equal steps, one step per 0.1 ms timebase tick. The target is the nominal voltage or one of two margin voltages, chosen by the operating command. A very short programmed rise time makes the setpoint jump to the target instead.

Turn-off has two phases: a hold for the turn-off delay, then a stepped fall of the setpoint to zero. If the rail is commanded on again while it is still turning off, the block treats this as a short cycle. It freezes the setpoint, waits out the restart delay, and starts a fresh turn-on sequence from the setpoint it froze. Each falling edge on the run input makes the block pull that pin low for the restart delay. A turn-on watchdog raises a latched fault if the output does not reach its undervoltage threshold within a programmed limit. All time values are counted in timebase ticks.

Top module: `rail_ramp_sequencer`

## Requirements
- R1: While reset is held, and after reset with the rail disabled, `state` is 0, `setpoint` is 0, and `run_pd` and `ton_fault` are low.
- R2: With the rail enabled and `rise_t` of 3 or more, the block stays `on_dly` ticks in state 1. It then spends `rise_t` or `rise_t`+1 ticks in state 2 while the setpoint moves monotonically toward the target, and enters state 3 with the setpoint equal to the target.
- R3: With `rise_t` below 3 (under 0.25 ms), the end of the turn-on delay takes the block straight from state 1 to state 3, with the setpoint already equal to the target. State 2 is never visited.
- R4: `op_cmd` selects the target: 0 = rail off, 1 = `v_nom`, 2 = `v_mlo`, 3 = `v_mhi`. A command change while in state 3 ramps the setpoint from its present value to the new target, using `rise_t`.
- R5: Disabling the rail from state 1, 2 or 3 enters state 4. The setpoint is held for `off_dly` ticks. The block then spends `fall_t` or `fall_t`+1 ticks in state 5 while the setpoint falls monotonically, and finishes in state 0 with the setpoint at 0.
- R6: Re-enabling the rail in state 4 or 5 is a short cycle. The block enters state 6 with the setpoint frozen, stays there `restart_t` ticks, then passes through state 1 and ramps from the frozen value to the target.
- R7: Each falling edge on `run_in` asserts `run_pd` on the next clock. `run_pd` stays high for exactly `restart_t` ticks (none if `restart_t` is 0).
- R8: If `uv_ok` has not been seen high after `ton_max` ticks in states 2 and 3, counted from entry to state 2, `ton_fault` rises and the block goes to state 0 with the setpoint at 0. The block stays there, with the fault latched, until the rail is disabled; disabling clears the fault.
- R9: A `ton_max` of 0 disables the turn-on watchdog.
- R10: State codes: 0 off, 1 turn-on delay, 2 rising, 3 on, 4 turn-off delay, 5 falling, 6 restart hold; code 7 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse every 0.1 ms; advances all timers and ramp steps |
| run_in | input | 1 | Level of the rail's run pin |
| op_cmd | input | 2 | Operating command: 0 off, 1 nominal, 2 margin low, 3 margin high |
| v_nom | input | CODE_W | Nominal setpoint code |
| v_mlo | input | CODE_W | Margin-low setpoint code |
| v_mhi | input | CODE_W | Margin-high setpoint code |
| on_dly | input | TIME_W | Turn-on delay in ticks |
| rise_t | input | TIME_W | Rise time in ticks (number of ramp steps) |
| off_dly | input | TIME_W | Turn-off delay in ticks |
| fall_t | input | TIME_W | Fall time in ticks |
| ton_max | input | TIME_W | Turn-on watchdog limit in ticks, 0 disables |
| restart_t | input | TIME_W | Restart delay in ticks |
| uv_ok | input | 1 | Output is above its undervoltage limit |
| setpoint | output | CODE_W | Voltage setpoint code |
| run_pd | output | 1 | Pull-down request for the run pin |
| ton_fault | output | 1 | Latched turn-on timeout fault |
| state | output | 3 | Sequencer state code |

## Verification
The stepped ramp is driven with step counts that divide the voltage span unevenly. It is also driven with a count larger than the span, where most ticks add nothing, and with counts just below and at the jump threshold. These cases tell exact arrival on target apart from drift or overshoot, and the jump path apart from a ramp. Targets are changed upward and downward while on, to separate a ramp from the present setpoint from one that restarts at zero. Re-enables during the turn-off delay and during the fall show the freeze and restart hold. Watchdog runs with the threshold never reached, reached early, and disabled separate fault timing from a false trip.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_ON_DLY  = 3'd1,
        ST_RISE    = 3'd2,
        ST_ON      = 3'd3,
        ST_OFF_DLY = 3'd4,
        ST_FALL    = 3'd5,
        ST_HOLD    = 3'd6
    } rail_state_e;

    typedef enum logic [1:0] {
        CMD_OFF = 2'd0,
        CMD_NOM = 2'd1,
        CMD_MLO = 2'd2,
        CMD_MHI = 2'd3
    } rail_cmd_e;

    // Step counts below this (0.25 ms at 0.1 ms per tick) jump instead of ramping
    localparam int SKIP_TICKS = 3;

    function automatic logic is_jump(input logic [31:0] steps);
        return steps < 32'(SKIP_TICKS);
    endfunction

endpackage

// File: rtl/rail_seq_div.sv
module rail_seq_div #(
    parameter int DVD_W = 12,
    parameter int DVS_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             busy,
    output logic [DVD_W-1:0] quo,
    output logic [DVS_W-1:0] rem
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [CNT_W-1:0] left;
    logic [DVD_W-1:0] shq;
    logic [DVS_W:0]   acc;
    logic [DVS_W:0]   dvs_q;
    logic [DVS_W:0]   trial;
    logic             fits;

    always_comb begin
        trial = {acc[DVS_W-1:0], shq[DVD_W-1]};
        fits  = trial >= dvs_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left  <= '0;
            shq   <= '0;
            acc   <= '0;
            dvs_q <= '0;
        end else if (start) begin
            left  <= CNT_W'(DVD_W);
            shq   <= dividend;
            acc   <= '0;
            dvs_q <= {1'b0, divisor};
        end else if (left != '0) begin
            acc  <= fits ? trial - dvs_q : trial;
            shq  <= {shq[DVD_W-2:0], fits};
            left <= left - 1'b1;
        end
    end

    assign busy = left != '0;
    assign quo  = shq;
    assign rem  = acc[DVS_W-1:0];

    // R2: the remainder of a finished division is below the divisor
    a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (acc < dvs_q));

endmodule

// File: rtl/rail_seq_ramp.sv
module rail_seq_ramp
    import rail_seq_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int STEP_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic              freeze,
    input  logic              zero,
    input  logic [CODE_W-1:0] to_code,
    input  logic [STEP_W-1:0] steps,
    output logic [CODE_W-1:0] sp,
    output logic              done
);
    typedef enum logic [1:0] {PH_IDLE, PH_DIV, PH_STEP} ph_e;

    ph_e               ph;
    logic              up;
    logic [CODE_W-1:0] to_q;
    logic [STEP_W-1:0] n_q;
    logic [STEP_W-1:0] cnt;
    logic [STEP_W:0]   err;
    logic              jump;
    logic [CODE_W-1:0] delta;
    logic              div_go;
    logic              div_busy;
    logic [CODE_W-1:0] quo;
    logic [STEP_W-1:0] rem;
    logic [STEP_W:0]   err_sum;
    logic              carry;
    logic [CODE_W-1:0] inc;

    always_comb begin
        jump    = is_jump(32'(steps));
        delta   = (to_code >= sp) ? to_code - sp : sp - to_code;
        div_go  = start && !jump && !zero && !freeze;
        err_sum = err + {1'b0, rem};
        carry   = err_sum >= {1'b0, n_q};
        inc     = quo + CODE_W'(carry);
    end

    rail_seq_div #(.DVD_W(CODE_W), .DVS_W(STEP_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_go),
        .dividend (delta),
        .divisor  (steps),
        .busy     (div_busy),
        .quo      (quo),
        .rem      (rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            up   <= 1'b0;
            to_q <= '0;
            n_q  <= '0;
            cnt  <= '0;
            err  <= '0;
            sp   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (zero) begin
                sp <= '0;
                ph <= PH_IDLE;
            end else if (freeze) begin
                ph <= PH_IDLE;
            end else if (start) begin
                if (jump) begin
                    sp <= to_code;
                    ph <= PH_IDLE;
                end else begin
                    up   <= to_code >= sp;
                    to_q <= to_code;
                    n_q  <= steps;
                    ph   <= PH_DIV;
                end
            end else begin
                case (ph)
                    PH_DIV: if (!div_busy) begin
                        err <= '0;
                        cnt <= '0;
                        ph  <= PH_STEP;
                    end
                    PH_STEP: if (tick) begin
                        sp  <= up ? sp + inc : sp - inc;
                        err <= carry ? err_sum - {1'b0, n_q} : err_sum;
                        cnt <= cnt + 1'b1;
                        if (cnt == n_q - 1'b1) begin
                            ph   <= PH_IDLE;
                            done <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: a running ramp never passes its target
    a_r2_no_overshoot: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_STEP) |-> (up ? (sp <= to_q) : (sp >= to_q)));

    // R3: a short step count lands the setpoint on the target at once
    a_r3_jump_lands: assert property (@(posedge clk) disable iff (rst)
        (start && jump && !zero && !freeze) |=> (sp == $past(to_code)));

endmodule

// File: rtl/rail_seq_pd.sv
module rail_seq_pd #(
    parameter int TIME_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run_in,
    input  logic [TIME_W-1:0] hold_t,
    output logic              pd
);
    logic              run_q;
    logic [TIME_W-1:0] cnt;
    logic              fall_seen;

    assign fall_seen = run_q && !run_in;

    always_ff @(posedge clk) begin
        run_q <= run_in;
        if (rst) begin
            cnt <= '0;
        end else if (fall_seen) begin
            cnt <= hold_t;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign pd = cnt != '0;

    // R7: a falling edge on the run pin starts the pull-down
    a_r7_pd_on_fall: assert property (@(posedge clk) disable iff (rst)
        ($fell(run_in) && hold_t != '0) |=> pd);

endmodule

// File: rtl/rail_ramp_sequencer.sv
module rail_ramp_sequencer
    import rail_seq_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int TIME_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run_in,
    input  logic [1:0]        op_cmd,
    input  logic [CODE_W-1:0] v_nom,
    input  logic [CODE_W-1:0] v_mlo,
    input  logic [CODE_W-1:0] v_mhi,
    input  logic [TIME_W-1:0] on_dly,
    input  logic [TIME_W-1:0] rise_t,
    input  logic [TIME_W-1:0] off_dly,
    input  logic [TIME_W-1:0] fall_t,
    input  logic [TIME_W-1:0] ton_max,
    input  logic [TIME_W-1:0] restart_t,
    input  logic              uv_ok,
    output logic [CODE_W-1:0] setpoint,
    output logic              run_pd,
    output logic              ton_fault,
    output logic [2:0]        state
);
    rail_state_e       st, nx;
    logic [TIME_W-1:0] dly;
    logic [TIME_W-1:0] ton_cnt;
    logic              uv_seen;
    logic              fault;
    logic              en;
    logic              ton_on;
    logic              ton_hit;
    logic [CODE_W-1:0] target;
    logic              r_start, r_freeze, r_zero, r_done;
    logic [CODE_W-1:0] r_to;
    logic [TIME_W-1:0] r_steps;
    logic              ld;
    logic [TIME_W-1:0] ld_val;

    always_comb begin
        en     = run_in && (rail_cmd_e'(op_cmd) != CMD_OFF);
        ton_on = (st == ST_RISE) || (st == ST_ON);
        ton_hit = ton_on && (ton_max != '0) && !uv_seen && !uv_ok && (ton_cnt >= ton_max);
        case (rail_cmd_e'(op_cmd))
            CMD_MLO: target = v_mlo;
            CMD_MHI: target = v_mhi;
            default: target = v_nom;
        endcase
    end

    always_comb begin
        nx       = st;
        r_start  = 1'b0;
        r_freeze = 1'b0;
        r_zero   = 1'b0;
        r_to     = target;
        r_steps  = rise_t;
        ld       = 1'b0;
        ld_val   = '0;
        case (st)
            ST_OFF: if (en && !fault) begin
                nx = ST_ON_DLY; ld = 1'b1; ld_val = on_dly;
            end
            ST_ON_DLY: if (!en) begin
                nx = ST_OFF_DLY; ld = 1'b1; ld_val = off_dly;
            end else if (dly == '0) begin
                r_start = 1'b1;
                nx = is_jump(32'(rise_t)) ? ST_ON : ST_RISE;
            end
            ST_RISE: if (ton_hit) begin
                r_zero = 1'b1; nx = ST_OFF;
            end else if (!en) begin
                r_freeze = 1'b1; nx = ST_OFF_DLY; ld = 1'b1; ld_val = off_dly;
            end else if (r_done) begin
                nx = ST_ON;
            end
            ST_ON: if (ton_hit) begin
                r_zero = 1'b1; nx = ST_OFF;
            end else if (!en) begin
                nx = ST_OFF_DLY; ld = 1'b1; ld_val = off_dly;
            end else if (setpoint != target) begin
                r_start = 1'b1;
                nx = is_jump(32'(rise_t)) ? ST_ON : ST_RISE;
            end
            ST_OFF_DLY: if (en) begin
                nx = ST_HOLD; ld = 1'b1; ld_val = restart_t;
            end else if (dly == '0) begin
                r_start = 1'b1; r_to = '0; r_steps = fall_t;
                nx = is_jump(32'(fall_t)) ? ST_OFF : ST_FALL;
            end
            ST_FALL: if (en) begin
                r_freeze = 1'b1; nx = ST_HOLD; ld = 1'b1; ld_val = restart_t;
            end else if (r_done) begin
                nx = ST_OFF;
            end
            ST_HOLD: if (!en) begin
                nx = ST_OFF_DLY; ld = 1'b1; ld_val = off_dly;
            end else if (dly == '0) begin
                nx = ST_ON_DLY; ld = 1'b1; ld_val = on_dly;
            end
            default: nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_OFF;
            dly     <= '0;
            ton_cnt <= '0;
            uv_seen <= 1'b0;
            fault   <= 1'b0;
        end else begin
            st <= nx;
            if (ld)
                dly <= ld_val;
            else if (tick && dly != '0)
                dly <= dly - 1'b1;
            if (!ton_on) begin
                ton_cnt <= '0;
                uv_seen <= 1'b0;
            end else begin
                if (uv_ok)
                    uv_seen <= 1'b1;
                if (tick && !uv_seen && ton_cnt < ton_max)
                    ton_cnt <= ton_cnt + 1'b1;
            end
            if (ton_hit)
                fault <= 1'b1;
            else if (!en)
                fault <= 1'b0;
        end
    end

    rail_seq_ramp #(.CODE_W(CODE_W), .STEP_W(TIME_W)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (r_start),
        .freeze  (r_freeze),
        .zero    (r_zero),
        .to_code (r_to),
        .steps   (r_steps),
        .sp      (setpoint),
        .done    (r_done)
    );

    rail_seq_pd #(.TIME_W(TIME_W)) u_pd (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run_in (run_in),
        .hold_t (restart_t),
        .pd     (run_pd)
    );

    assign ton_fault = fault;
    assign state     = st;

    // R5: the setpoint does not move during the turn-off delay
    a_r5_offdly_holds: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OFF_DLY) |=> (st != ST_OFF_DLY || $stable(setpoint)));

    // R6: the setpoint is frozen during the restart hold
    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |=> (st != ST_HOLD || $stable(setpoint)));

    // R8: a latched turn-on fault keeps the rail off at zero
    a_r8_fault_parks: assert property (@(posedge clk) disable iff (rst)
        ton_fault |-> (st == ST_OFF && setpoint == '0));

    // R10: the unused state code never appears
    a_r10_state_legal: assert property (@(posedge clk) disable iff (rst)
        state != 3'd7);

endmodule

// File: tb/sim_rail_ramp_sequencer.sv
module sim_rail_ramp_sequencer;
    localparam int CLK_P     = 10;
    localparam int TICK_CLKS = 16;
    localparam int CW        = 12;
    localparam int TW        = 20;
    localparam int VEC_N     = 6;
    // rise ticks, command, expected final setpoint
    localparam int VEC [VEC_N][3] = '{
        '{10,   1, 1000},
        '{7,    2, 900},
        '{2,    3, 1100},
        '{0,    1, 1000},
        '{3,    3, 1100},
        '{1500, 1, 1000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          run_in = 1'b0;
    logic [1:0]    op_cmd = 2'd0;
    logic [CW-1:0] v_nom = CW'(1000), v_mlo = CW'(900), v_mhi = CW'(1100);
    logic [TW-1:0] on_dly = TW'(2), rise_t = TW'(10), off_dly = TW'(5);
    logic [TW-1:0] fall_t = TW'(8), ton_max = '0, restart_t = TW'(4);
    logic          uv_ok = 1'b1;
    logic [CW-1:0] setpoint;
    logic          run_pd, ton_fault;
    logic [2:0]    state;

    int n_chk = 0, n_bad = 0;
    int rise_ticks = 0, rise_clks = 0, offd_ticks = 0, fall_ticks = 0, hold_ticks = 0, pd_ticks = 0;
    int mono_bad = 0;
    bit mono_up = 1'b1;
    logic [CW-1:0] prev_sp = '0;

    rail_ramp_sequencer #(.CODE_W(CW), .TIME_W(TW)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .run_in(run_in), .op_cmd(op_cmd),
        .v_nom(v_nom), .v_mlo(v_mlo), .v_mhi(v_mhi), .on_dly(on_dly),
        .rise_t(rise_t), .off_dly(off_dly), .fall_t(fall_t), .ton_max(ton_max),
        .restart_t(restart_t), .uv_ok(uv_ok), .setpoint(setpoint),
        .run_pd(run_pd), .ton_fault(ton_fault), .state(state)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        forever begin
            repeat (TICK_CLKS - 1) @(posedge clk);
            #1 tick = 1'b1;
            @(posedge clk);
            #1 tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (state == 3'd2) rise_clks++;
        if (tick) begin
            if (state == 3'd2) rise_ticks++;
            if (state == 3'd4) offd_ticks++;
            if (state == 3'd5) fall_ticks++;
            if (state == 3'd6) hold_ticks++;
            if (run_pd) pd_ticks++;
        end
        if (state == 3'd2 && (mono_up ? setpoint < prev_sp : setpoint > prev_sp)) mono_bad++;
        if (state == 3'd5 && setpoint > prev_sp) mono_bad++;
        prev_sp = setpoint;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_counts();
        @(posedge clk);
        #2;
        rise_ticks = 0; rise_clks = 0; offd_ticks = 0; fall_ticks = 0;
        hold_ticks = 0; pd_ticks = 0; mono_bad = 0;
    endtask

    task automatic wait_st(input int s, input string tag);
        int k = 0;
        while (int'(state) != s && k < 60000) begin
            @(negedge clk);
            k++;
        end
        chk(int'(state) == s, tag, int'(state), s);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!tick);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_P * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int cap;
        repeat (4) @(negedge clk);
        // R1 / R10: reset state
        chk(state == 3'd0 && setpoint == '0 && !run_pd && !ton_fault, "R1 reset outputs",
            int'(state) + int'(setpoint), 0);
        rst = 1'b0;
        run_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(state == 3'd0 && setpoint == '0, "R1 disabled after reset", int'(state), 0);

        // Vector table: R2, R3, R4
        for (int v = 0; v < VEC_N; v++) begin
            clr_counts();
            @(negedge clk);
            rise_t  = TW'(VEC[v][0]);
            mono_up = 1'b1;
            op_cmd  = 2'(VEC[v][1]);
            wait_st(3, "R2 reaches on");
            chk(int'(setpoint) == VEC[v][2], "R4 target code", int'(setpoint), VEC[v][2]);
            if (VEC[v][0] < 3)
                chk(rise_clks == 0, "R3 jump skips rising", rise_clks, 0);
            else
                chk(rise_ticks == VEC[v][0] || rise_ticks == VEC[v][0] + 1, "R2 step count",
                    rise_ticks, VEC[v][0]);
            chk(mono_bad == 0, "R2 monotonic rise", mono_bad, 0);
            @(negedge clk);
            op_cmd = 2'd0;
            wait_st(0, "R5 back to off");
        end

        // R4: margin changes while on
        rise_t = TW'(10);
        @(negedge clk);
        op_cmd = 2'd1;
        wait_st(3, "R4 on nominal");
        clr_counts();
        @(negedge clk);
        mono_up = 1'b1;
        op_cmd  = 2'd3;
        wait_st(2, "R4 ramp up to margin high");
        wait_st(3, "R4 on margin high");
        chk(setpoint == CW'(1100), "R4 margin high from nominal", int'(setpoint), 1100);
        @(negedge clk);
        mono_up = 1'b0;
        op_cmd  = 2'd2;
        wait_st(2, "R4 ramp down to margin low");
        wait_st(3, "R4 on margin low");
        chk(setpoint == CW'(900), "R4 margin low", int'(setpoint), 900);
        chk(mono_bad == 0, "R4 monotonic margin ramps", mono_bad, 0);

        // R5: turn-off delay then fall
        clr_counts();
        @(negedge clk);
        op_cmd = 2'd0;
        wait_st(4, "R5 turn-off delay");
        wait_st(5, "R5 falling");
        chk(offd_ticks == 5, "R5 turn-off delay ticks", offd_ticks, 5);
        chk(setpoint == CW'(900), "R5 setpoint held in delay", int'(setpoint), 900);
        wait_st(0, "R5 off");
        chk(setpoint == '0, "R5 fall ends at zero", int'(setpoint), 0);
        chk(fall_ticks == 8 || fall_ticks == 9, "R5 fall ticks", fall_ticks, 8);
        chk(mono_bad == 0, "R5 monotonic fall", mono_bad, 0);

        // R6: short cycle during falling
        mono_up = 1'b1;
        fall_t  = TW'(20);
        @(negedge clk);
        op_cmd = 2'd1;
        wait_st(3, "R6 on before short cycle");
        @(negedge clk);
        op_cmd = 2'd0;
        wait_st(5, "R6 falling");
        wait_ticks(5);
        clr_counts();
        @(negedge clk);
        cap    = int'(setpoint);
        op_cmd = 2'd1;
        @(negedge clk);
        chk(state == 3'd6, "R6 short cycle enters hold", int'(state), 6);
        wait_st(1, "R6 hold ends in turn-on delay");
        chk(hold_ticks == 4, "R6 hold ticks", hold_ticks, 4);
        chk(int'(setpoint) == cap && cap > 0 && cap < 1000, "R6 setpoint frozen", int'(setpoint), cap);
        wait_st(3, "R6 back on");
        chk(setpoint == CW'(1000), "R6 ramp from frozen value", int'(setpoint), 1000);
        chk(rise_ticks == 10 || rise_ticks == 11, "R6 fresh rise steps", rise_ticks, 10);

        // R6: short cycle during the turn-off delay
        @(negedge clk);
        op_cmd = 2'd0;
        wait_st(4, "R6 turn-off delay");
        wait_ticks(2);
        @(negedge clk);
        op_cmd = 2'd1;
        @(negedge clk);
        chk(state == 3'd6, "R6 short cycle from turn-off delay", int'(state), 6);
        wait_st(3, "R6 on again");

        // R7: run pin pull-down
        clr_counts();
        @(negedge clk);
        run_in = 1'b0;
        @(negedge clk);
        chk(run_pd == 1'b1, "R7 pull-down asserted", int'(run_pd), 1);
        wait_ticks(7);
        chk(pd_ticks == 4, "R7 pull-down ticks", pd_ticks, 4);
        chk(run_pd == 1'b0, "R7 pull-down released", int'(run_pd), 0);
        wait_st(0, "R7 off after run low");

        // R8: turn-on timeout
        fall_t  = TW'(8);
        op_cmd  = 2'd0;
        ton_max = TW'(6);
        uv_ok   = 1'b0;
        @(negedge clk);
        run_in = 1'b1;
        clr_counts();
        @(negedge clk);
        op_cmd = 2'd1;
        wait_st(2, "R8 rising");
        wait_st(0, "R8 fault forces off");
        chk(ton_fault == 1'b1 && setpoint == '0, "R8 fault and zero", int'(ton_fault), 1);
        chk(rise_ticks == 6, "R8 timeout ticks", rise_ticks, 6);
        wait_ticks(5);
        chk(state == 3'd0 && ton_fault, "R8 latched, no restart", int'(state), 0);
        @(negedge clk);
        op_cmd = 2'd0;
        repeat (2) @(negedge clk);
        chk(ton_fault == 1'b0, "R8 fault cleared by disable", int'(ton_fault), 0);
        uv_ok = 1'b1;
        @(negedge clk);
        op_cmd = 2'd1;
        wait_st(3, "R8 on with threshold reached");
        wait_ticks(10);
        chk(ton_fault == 1'b0 && state == 3'd3, "R8 no fault when reached", int'(ton_fault), 0);
        @(negedge clk);
        op_cmd = 2'd0;
        wait_st(0, "R8 off");

        // R9: watchdog disabled
        ton_max = '0;
        uv_ok   = 1'b0;
        @(negedge clk);
        op_cmd = 2'd1;
        wait_st(3, "R9 on without threshold");
        wait_ticks(20);
        chk(ton_fault == 1'b0 && state == 3'd3, "R9 disabled watchdog", int'(ton_fault), 0);

        summary();
        $finish;
    end
endmodule